// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the 256-byte type-0 configuration space of a single-function bridge. A host-side decoder, outside this block, presents a function number, a byte offset, write data and a write or read strobe. The block stores the byte according to that offset's rules: a write mask, bits forced to one, write-one-to-clear status bits, or a status byte that a lock bit elsewhere in the space makes read-only. A read returns the stored byte in the same cycle.

Only function 0 exists. A read of any other function returns all ones, and a write to any other function is dropped. Identification and header bytes are fixed values loaded at reset. Two fields are driven out to neighbouring logic: the interrupt level-conversion enable and the routing nibbles of the first two interrupt pins.

Top module: `bridge_cfg_space`

## Requirements
- R1: After reset, offsets 0x00..0x03 read 0x45, 0x10, 0x22, 0xC8. Offset 0x04 reads 0x07, 0x06 reads 0x80, 0x07 reads 0x02, 0x08 reads 0x01, 0x0B reads 0x06 and 0x0D reads 0x20.
- R2: After reset, 0x40 reads 0x01, 0x41 reads 0x0C, 0x43 reads 0x02, 0x52 reads 0x06 and 0x53 reads 0x90. Every other offset reads 0x00.
- R3: A write to 0x04 stores (data & 0x40) | 0x07, so bits 2:0 always read as one.
- R4: A write to 0x06 stores data & 0x80 while bit 2 of 0x52 is 0. While that bit is 1 the write leaves 0x06 unchanged.
- R5: A write to 0x07 clears each stored bit for which the data bit is 1 and mask 0xF9 is 1. Other stored bits are kept.
- R6: A write to 0x40 stores (data & 0xC0) | 0x01. 0x41 stores data & 0xCF and 0x42 stores data & 0xF8.
- R7: Writes to 0x58, 0x60, 0x68, 0x70 and 0x79 store data & 0xFC. 0x74 stores data & 0xF8 and 0x7F stores data & 0x03.
- R8: With a nonzero function number, a read returns 0xFF and a write changes no byte.
- R9: Offsets 0x00..0x03, 0x08..0x0C and 0x0E..0x3F ignore writes. 0x0D, 0x43, 0x45..0x82, 0x84..0x86 and 0x88..0x8F store the full byte, except for the masked offsets above. All remaining offsets, for example 0x05, 0x44, 0x83 and 0x90..0xFF, read 0x00 and ignore writes.
- R10: level_conv_en equals bit 3 of 0x53. pin_route equals {byte 0x81, byte 0x80}.
- R11: Read data is combinational from the offset in the same cycle, and it reads 0x00 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_num | input | FUNC_W | Function number of the access |
| reg_off | input | 8 | Byte offset in configuration space |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data |
| level_conv_en | output | 1 | Interrupt level-to-edge conversion enable |
| pin_route | output | 16 | Routing nibbles for the first interrupt pins |

## Verification
Every stored byte can be read on the next read strobe, so a wrong mask or a wrong forced bit shows up on the first read-back after the write. Nothing is hidden behind a pipeline. A lock bit that is decoded wrongly shows only when 0x06 is written with 0x52 in the other lock state, so the bench toggles the lock both ways. Corruption caused by a write to a foreign function stays invisible until the touched offset is read back, so each such write is followed by a read of the same offset under function 0.

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space #(
  parameter int FUNC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FUNC_W-1:0] fn_num,
  input  logic [7:0]        reg_off,
  input  logic [7:0]        wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              level_conv_en,
  output logic [15:0]       pin_route
);

  localparam int NBYTES = 256;

  logic [NBYTES-1:0][7:0] cfg;
  logic                   fn_zero;
  logic [15:0]            rule;

  assign fn_zero = (fn_num == '0);

  function automatic logic [7:0] reset_val(input logic [7:0] a);
    case (a)
      8'h00: return 8'h45;
      8'h01: return 8'h10;
      8'h02: return 8'h22;
      8'h03: return 8'hC8;
      8'h04: return 8'h07;
      8'h06: return 8'h80;
      8'h07: return 8'h02;
      8'h08: return 8'h01;
      8'h0B: return 8'h06;
      8'h0D: return 8'h20;
      8'h40: return 8'h01;
      8'h41: return 8'h0C;
      8'h43: return 8'h02;
      8'h52: return 8'h06;
      8'h53: return 8'h90;
      default: return 8'h00;
    endcase
  endfunction

  // {write mask, forced ones}
  function automatic logic [15:0] wr_rule(input logic [7:0] a);
    case (a)
      8'h04: return {8'h40, 8'h07};
      8'h0D: return {8'hFF, 8'h00};
      8'h40: return {8'hC0, 8'h01};
      8'h41: return {8'hCF, 8'h00};
      8'h42: return {8'hF8, 8'h00};
      8'h43: return {8'hFF, 8'h00};
      8'h58, 8'h60, 8'h68, 8'h70, 8'h79: return {8'hFC, 8'h00};
      8'h74: return {8'hF8, 8'h00};
      8'h7F: return {8'h03, 8'h00};
      default:
        if ((a >= 8'h45 && a <= 8'h82) || (a >= 8'h84 && a <= 8'h86) ||
            (a >= 8'h88 && a <= 8'h8F))
          return {8'hFF, 8'h00};
        else
          return 16'h0000;
    endcase
  endfunction

  assign rule = wr_rule(reg_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cfg[i] <= reset_val(8'(i));
    end else if (wr_en && fn_zero) begin
      if (reg_off == 8'h07)
        cfg[7] <= cfg[7] & ~(wr_data & 8'hF9);
      else if (reg_off == 8'h06) begin
        if (!cfg[8'h52][2]) cfg[6] <= wr_data & 8'h80;
      end else
        cfg[reg_off] <= (cfg[reg_off] & ~rule[15:8]) | (wr_data & rule[15:8]) | rule[7:0];
    end
  end

  assign rd_data       = !rd_en ? 8'h00 : (fn_zero ? cfg[reg_off] : 8'hFF);
  assign level_conv_en = cfg[8'h53][3];
  assign pin_route     = {cfg[8'h81], cfg[8'h80]};

  // R3
  cmd_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[4][2:0] == 3'b111);

  // R4
  status_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn_zero && reg_off == 8'h06 && cfg[8'h52][2]) |=> $stable(cfg[6]));

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn_zero && reg_off == 8'h07) |=> ((cfg[7] & $past(wr_data) & 8'hF9) == 8'h00));

  // R8
  foreign_fn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fn_zero) |=> $stable(cfg));

  // R1
  vendor_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cfg[0] == 8'h45 && cfg[1] == 8'h10));

endmodule

// File: tb/bridge_cfg_space_test.sv
module bridge_cfg_space_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  fn_num = 0;
  logic [7:0]  reg_off = 0, wr_data = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  rd_data;
  logic        level_conv_en;
  logic [15:0] pin_route;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bridge_cfg_space #(.FUNC_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .fn_num(fn_num), .reg_off(reg_off),
    .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .level_conv_en(level_conv_en), .pin_route(pin_route)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] f, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    fn_num = f; reg_off = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; fn_num = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] f, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    fn_num = f; reg_off = a; rd_en = 1;
    #1 check(req, {8'h00, rd_data}, {8'h00, exp});
    rd_en = 0; fn_num = 0;
  endtask

  task automatic test_reset;
    rd_chk("R1", 0, 8'h00, 8'h45); rd_chk("R1", 0, 8'h01, 8'h10);
    rd_chk("R1", 0, 8'h02, 8'h22); rd_chk("R1", 0, 8'h03, 8'hC8);
    rd_chk("R1", 0, 8'h04, 8'h07); rd_chk("R1", 0, 8'h06, 8'h80);
    rd_chk("R1", 0, 8'h07, 8'h02); rd_chk("R1", 0, 8'h08, 8'h01);
    rd_chk("R1", 0, 8'h0B, 8'h06); rd_chk("R1", 0, 8'h0D, 8'h20);
    rd_chk("R2", 0, 8'h40, 8'h01); rd_chk("R2", 0, 8'h41, 8'h0C);
    rd_chk("R2", 0, 8'h43, 8'h02); rd_chk("R2", 0, 8'h52, 8'h06);
    rd_chk("R2", 0, 8'h53, 8'h90); rd_chk("R2", 0, 8'h05, 8'h00);
    rd_chk("R2", 0, 8'h44, 8'h00); rd_chk("R2", 0, 8'hFF, 8'h00);
  endtask

  task automatic test_cmd;
    wr(0, 8'h04, 8'hFF); rd_chk("R3", 0, 8'h04, 8'h47);
    wr(0, 8'h04, 8'h00); rd_chk("R3", 0, 8'h04, 8'h07);
  endtask

  task automatic test_status_lock;
    wr(0, 8'h06, 8'h00); rd_chk("R4 locked", 0, 8'h06, 8'h80);
    wr(0, 8'h52, 8'h00);
    wr(0, 8'h06, 8'h00); rd_chk("R4 unlocked", 0, 8'h06, 8'h00);
    wr(0, 8'h06, 8'h7F); rd_chk("R4 mask", 0, 8'h06, 8'h00);
    wr(0, 8'h06, 8'hFF); rd_chk("R4 mask", 0, 8'h06, 8'h80);
    wr(0, 8'h52, 8'h04);
    wr(0, 8'h06, 8'h00); rd_chk("R4 relocked", 0, 8'h06, 8'h80);
  endtask

  task automatic test_w1c;
    wr(0, 8'h07, 8'h00); rd_chk("R5 zero data", 0, 8'h07, 8'h02);
    wr(0, 8'h07, 8'hFF); rd_chk("R5 unmasked bit kept", 0, 8'h07, 8'h02);
  endtask

  task automatic test_low_masks;
    wr(0, 8'h40, 8'hFF); rd_chk("R6", 0, 8'h40, 8'hC1);
    wr(0, 8'h40, 8'h00); rd_chk("R6", 0, 8'h40, 8'h01);
    wr(0, 8'h41, 8'hFF); rd_chk("R6", 0, 8'h41, 8'hCF);
    wr(0, 8'h42, 8'hFF); rd_chk("R6", 0, 8'h42, 8'hF8);
  endtask

  task automatic test_high_masks;
    wr(0, 8'h58, 8'hFF); rd_chk("R7", 0, 8'h58, 8'hFC);
    wr(0, 8'h60, 8'hFF); rd_chk("R7", 0, 8'h60, 8'hFC);
    wr(0, 8'h68, 8'hFF); rd_chk("R7", 0, 8'h68, 8'hFC);
    wr(0, 8'h70, 8'hFF); rd_chk("R7", 0, 8'h70, 8'hFC);
    wr(0, 8'h79, 8'hFF); rd_chk("R7", 0, 8'h79, 8'hFC);
    wr(0, 8'h74, 8'hFF); rd_chk("R7", 0, 8'h74, 8'hF8);
    wr(0, 8'h7F, 8'hFF); rd_chk("R7", 0, 8'h7F, 8'h03);
  endtask

  task automatic test_access_classes;
    wr(0, 8'h00, 8'hFF); rd_chk("R9 ro", 0, 8'h00, 8'h45);
    wr(0, 8'h0B, 8'h00); rd_chk("R9 ro", 0, 8'h0B, 8'h06);
    wr(0, 8'h20, 8'hFF); rd_chk("R9 ro", 0, 8'h20, 8'h00);
    wr(0, 8'h0D, 8'h5A); rd_chk("R9 full", 0, 8'h0D, 8'h5A);
    wr(0, 8'h43, 8'hA5); rd_chk("R9 full", 0, 8'h43, 8'hA5);
    wr(0, 8'h8F, 8'h3C); rd_chk("R9 full", 0, 8'h8F, 8'h3C);
    wr(0, 8'h45, 8'hFF); rd_chk("R9 full", 0, 8'h45, 8'hFF);
    wr(0, 8'h05, 8'hFF); rd_chk("R9 unused", 0, 8'h05, 8'h00);
    wr(0, 8'h44, 8'hFF); rd_chk("R9 unused", 0, 8'h44, 8'h00);
    wr(0, 8'h83, 8'hFF); rd_chk("R9 unused", 0, 8'h83, 8'h00);
    wr(0, 8'h90, 8'hFF); rd_chk("R9 unused", 0, 8'h90, 8'h00);
  endtask

  task automatic test_foreign_fn;
    rd_chk("R8 read", 1, 8'h00, 8'hFF);
    rd_chk("R8 read", 7, 8'h90, 8'hFF);
    wr(2, 8'h0D, 8'h11); rd_chk("R8 write", 0, 8'h0D, 8'h5A);
    wr(7, 8'h04, 8'h40); rd_chk("R8 write", 0, 8'h04, 8'h07);
  endtask

  task automatic test_outputs;
    wr(0, 8'h53, 8'h08);
    #1 check("R10 level", {15'd0, level_conv_en}, 16'h0001);
    wr(0, 8'h53, 8'hF7);
    #1 check("R10 level", {15'd0, level_conv_en}, 16'h0000);
    wr(0, 8'h80, 8'h21); wr(0, 8'h81, 8'h43);
    #1 check("R10 route", pin_route, 16'h4321);
  endtask

  task automatic test_rd_idle;
    @(negedge clk);
    reg_off = 8'h00; fn_num = 0; rd_en = 0;
    #1 check("R11 idle", {8'h00, rd_data}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset;
    test_cmd;
    test_status_lock;
    test_w1c;
    test_low_masks;
    test_high_masks;
    test_access_classes;
    test_foreign_fn;
    test_outputs;
    test_rd_idle;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule